// File: doc/BRIEF.md
# Data Store with Memory-Mapped Switches and LEDs

This block is the data-side memory of a small processor. A single CPU port presents a 9-bit word address, a write strobe and a 16-bit write word. It receives a 16-bit read word, which is a combinational function of the address. Most of the 512-word space is plain storage. The four highest addresses are reserved for devices.

The two lowest of those four reserved words hold switch inputs. Each switch pin passes through a two-flop synchronizer and is then copied into its word on every clock edge, whatever the CPU is doing. The two highest reserved words hold LED outputs. Each LED pin is driven from bit 0 of the word last written to its address, and the whole written word can be read back.

A two-stage reset synchronizer sits inside the block. Reset asserts asynchronously and releases on a clock edge.

Top module: `iomem_dmem`

## Requirements
- R1: A write (`wr_en`=1) to an address from 0x000 to 0x1FB stores `wdata` at the rising clock edge. A later read of that address returns the stored word.
- R2: `rdata` follows `addr` combinationally. A new address shows its word before the next clock edge.
- R3: With `wr_en`=0, no stored RAM word changes, whatever `addr` and `wdata` are.
- R4: Address 0x1FC reads as `{15'b0, sw_i[0]}` and address 0x1FD reads as `{15'b0, sw_i[1]}`. A pin change shows at the read port after the third rising edge that follows it and not before.
- R5: A CPU write to 0x1FC or 0x1FD has no effect. The word still follows its pin.
- R6: A write to 0x1FE or 0x1FF takes effect at the edge. After that edge, `led_o[0]` or `led_o[1]` equals bit 0 of the written word, and the address reads back the whole 16-bit word.
- R7: While reset is held, `led_o` is 0 and all four device addresses read 0.
- R8: Writes to RAM addresses leave `led_o` and the device words unchanged. Writes to LED addresses leave RAM words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 9 | Word address from the CPU |
| wr_en | input | 1 | 1 = write `wdata` at the edge, 0 = read only |
| wdata | input | 16 | Write word |
| rdata | output | 16 | Read word for `addr`, combinational |
| sw_i | input | 2 | Asynchronous switch pins |
| led_o | output | 2 | LED pins, bit 0 of each LED word |

## Verification
- RAM and read port: a read is due in the same cycle as its address, so the bench samples `rdata` one nanosecond after changing `addr`, with no clock edge in between. A written word is due after exactly one edge, so the bench changes inputs just after an edge and samples before the next.
- LED outputs: the bench samples `led_o` just after the write edge.
- Switch inputs: the bench changes a pin just after an edge. It then checks that the old value still reads after two edges and that the new value reads after the third.

// File: rtl/iomem_pkg.sv
package iomem_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 9;
  localparam int N_IN   = 2;
  localparam int N_OUT  = 2;
endpackage

// File: rtl/iomem_rstsync.sv
module iomem_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/iomem_insync.sv
module iomem_insync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] bit_o
);
  logic [N-1:0] meta_q, meta_d;
  logic [N-1:0] sync_q, sync_d;
  logic [N-1:0] bit_q,  bit_d;
  logic         smp_en;

  assign smp_en = 1'b1;

  always_comb begin
    meta_d = meta_q;
    sync_d = sync_q;
    bit_d  = bit_q;
    if (smp_en) begin
      meta_d = pin_i;
      sync_d = meta_q;
      bit_d  = sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      bit_q  <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      bit_q  <= bit_d;
    end
  end

  assign bit_o = bit_q;

  // R4: the stored bit trails the second synchronizer stage by one edge
  p_in_pipe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bit_q == $past(sync_q));
endmodule

// File: rtl/iomem_ram.sv
module iomem_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 9,
  parameter int WORDS  = 508
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];
  logic              in_range;

  assign in_range = (int'(addr) < WORDS);
  assign rdata    = in_range ? mem[addr] : '0;

  always_ff @(posedge clk) begin
    if (we && in_range) mem[addr] <= wdata;
  end

  p_ram_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && in_range) |=> mem[$past(addr)] == $past(wdata));

  p_ram_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && in_range) |=> mem[$past(addr)] == $past(rdata));
endmodule

// File: rtl/iomem_dmem.sv
module iomem_dmem
  import iomem_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int NI    = N_IN,
  parameter int NO    = N_OUT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NI-1:0] sw_i,
  output logic [NO-1:0] led_o
);
  localparam int DEPTH    = 1 << AW;
  localparam int IN_BASE  = DEPTH - NI - NO;
  localparam int OUT_BASE = DEPTH - NO;

  logic          rst_sync_n;
  logic [NI-1:0] sw_bit;
  logic [NI-1:0] in_hit;
  logic [NO-1:0] out_hit;
  logic          ram_we;
  logic [DW-1:0] ram_rdata;
  logic [DW-1:0] led_word_q [NO];
  logic [DW-1:0] led_word_d [NO];

  iomem_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  iomem_insync #(.N(NI)) u_in (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pin_i (sw_i),
    .bit_o (sw_bit)
  );

  assign ram_we = wr_en && (int'(addr) < IN_BASE);

  iomem_ram #(.DATA_W(DW), .ADDR_W(AW), .WORDS(IN_BASE)) u_ram (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (ram_we),
    .addr  (addr),
    .wdata (wdata),
    .rdata (ram_rdata)
  );

  for (genvar k = 0; k < NI; k++) begin : g_in_dec
    assign in_hit[k] = (int'(addr) == IN_BASE + k);
  end

  for (genvar k = 0; k < NO; k++) begin : g_out
    assign out_hit[k] = (int'(addr) == OUT_BASE + k);

    always_comb begin
      led_word_d[k] = led_word_q[k];
      if (wr_en && out_hit[k]) led_word_d[k] = wdata;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) led_word_q[k] <= '0;
      else             led_word_q[k] <= led_word_d[k];
    end

    assign led_o[k] = led_word_q[k][0];

    p_led_update_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (wr_en && out_hit[k]) |=> led_o[k] == $past(wdata[0]));

    p_led_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !(wr_en && out_hit[k]) |=> $stable(led_o[k]));
  end

  always_comb begin
    rdata = ram_rdata;
    for (int k = 0; k < NI; k++)
      if (in_hit[k]) rdata = {{(DW-1){1'b0}}, sw_bit[k]};
    for (int k = 0; k < NO; k++)
      if (out_hit[k]) rdata = led_word_q[k];
  end

  p_in_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|in_hit) |-> rdata[DW-1:1] == '0);

  p_dev_onehot_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({in_hit, out_hit}));
endmodule

// File: tb/iomem_dmem_test.sv
module iomem_dmem_test;
  logic        clk;
  logic        rst_n;
  logic [8:0]  addr;
  logic        wr_en;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [1:0]  sw_i;
  logic [1:0]  led_o;

  int n_chk;
  int n_bad;

  iomem_dmem uut (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr_en (wr_en),
    .wdata (wdata),
    .rdata (rdata),
    .sw_i  (sw_i),
    .led_o (led_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] pat(int a, logic [15:0] seed);
    logic [15:0] v;
    v = 16'(a) * 16'd40503 + seed;
    return v ^ (16'(a) << 7);
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_wr(int a, logic [15:0] d, logic en);
    addr  = 9'(a);
    wdata = d;
    wr_en = en;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic do_rd(int a, output logic [15:0] d);
    addr = 9'(a);
    #1;
    d = rdata;
  endtask

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    addr  = '0;
    wr_en = 1'b0;
    wdata = '0;
    sw_i  = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state with switches high
    chk("R7 led", {14'b0, led_o}, 16'h0);
    for (int a = 508; a < 512; a++) begin
      do_rd(a, v);
      chk("R7 dev word", v, 16'h0);
    end
    rst_n = 1'b1;
    sw_i  = 2'b00;
    repeat (6) @(posedge clk);
    #1;

    // R1: fill and read back all RAM words
    for (int a = 0; a < 508; a++) do_wr(a, pat(a, 16'h1234), 1'b1);
    for (int a = 0; a < 508; a++) begin
      do_rd(a, v);
      chk("R1 ram", v, pat(a, 16'h1234));
    end

    // R3: strobe low, nothing stored
    for (int a = 0; a < 508; a++) do_wr(a, pat(a, 16'hBEEF), 1'b0);
    for (int a = 0; a < 508; a++) begin
      do_rd(a, v);
      chk("R3 ram hold", v, pat(a, 16'h1234));
    end

    // R2: combinational read, address changed with the clock high, no edge between
    @(posedge clk);
    #2;
    addr = 9'd17;
    #1;
    chk("R2 comb a", rdata, pat(17, 16'h1234));
    addr = 9'd300;
    #1;
    chk("R2 comb b", rdata, pat(300, 16'h1234));

    // R6 / R8: LED writes
    for (int k = 0; k < 2; k++) begin
      for (int p = 0; p < 4; p++) begin
        logic [15:0] w;
        w = 16'hA5A4 ^ 16'(p * 16'h1111) ^ 16'(p & 1);
        do_wr(510 + k, w, 1'b1);
        chk("R6 led pin", {15'b0, led_o[k]}, {15'b0, w[0]});
        do_rd(510 + k, v);
        chk("R6 led readback", v, w);
      end
    end
    do_wr(510, 16'h0001, 1'b1);
    do_wr(511, 16'h0000, 1'b1);
    for (int a = 0; a < 508; a += 37) begin
      do_wr(a, 16'hFFFE ^ 16'(a), 1'b1);
      chk("R8 led untouched", {14'b0, led_o}, 16'h0001);
    end
    do_rd(510, v);
    chk("R8 led word", v, 16'h0001);
    do_rd(37, v);
    chk("R8 ram kept", v, 16'hFFFE ^ 16'd37);
    do_rd(38, v);
    chk("R8 ram neighbour", v, pat(38, 16'h1234));
    do_rd(507, v);
    chk("R8 ram top", v, pat(507, 16'h1234));

    // R4: switch latency, every pin value
    for (int k = 0; k < 2; k++) begin
      for (int p = 0; p < 2; p++) begin
        logic old_b;
        old_b = (p == 0) ? 1'b0 : 1'b1;
        sw_i[k] = ~old_b;
        addr = 9'(508 + k);
        @(posedge clk); @(posedge clk);
        #1;
        chk("R4 before third edge", rdata, {15'b0, old_b});
        @(posedge clk);
        #1;
        chk("R4 after third edge", rdata, {15'b0, ~old_b});
      end
    end

    // R5: writes to switch words ignored
    sw_i = 2'b10;
    repeat (4) @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      do_wr(508 + k, 16'hFFFF ^ 16'(k), 1'b1);
      do_rd(508 + k, v);
      chk("R5 switch write ignored", v, {15'b0, sw_i[k]});
      do_rd(508 + k, v);
    end
    do_rd(510, v);
    chk("R5 led unaffected", v, 16'h0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule